// File: doc/BRIEF.md
# Dual-Channel LCD Segment Driver

This block turns serial display data into steady per-segment drive selections for a segmented LCD. It holds two independent channels of 40 segments each. Each channel has a serial shift register whose direction can be chosen, a 40-bit hold latch, and a per-segment level selector. Channel 0 drives segments 0 to 39 and channel 1 drives segments 40 to 79.

A display controller sends bits while pulsing a shift strobe, then pulses a latch strobe to show the new frame. A single system clock samples both strobes, the frame-phase input and the serial data pins through a two-stage synchronizer. The block acts only on falling edges of the strobes.

Each channel has two serial pins, a left one and a right one. Each pin is modelled as an input, an output and an output enable. The direction select decides which pin receives data and which one passes the far-end bit on to the next driver in a chain. Each segment output is a 2-bit code that names one of four bias voltages, chosen from the latched bit and the frame phase.

Top module: `dual_seg_driver`

## Requirements
- R1: A synchronous active-high reset clears both shift registers and both latches. Afterwards every enabled serial output is 0, and every segment code is `{1, ~phase}`: 2'b11 while `alt_in` is low and 2'b10 while it is high.
- R2: A shift register changes only after a falling edge of `shift_stb`. A rising edge or a steady high level on `shift_stb` leaves the serial outputs and the segment codes unchanged.
- R3: On a falling edge of `latch_stb`, all 40 register bits of each channel are copied into that channel's latch. Further shifting leaves the segment codes unchanged until the next falling edge of `latch_stb`.
- R4: When `dir_sel[c]` is 1, bits enter at segment 39 of channel c from `rpin_i[c]` and move toward segment 0. `lpin_oe[c]`=1 and `lpin_o[c]` shows register bit 0. `rpin_oe[c]`=0, and `lpin_i[c]` is ignored.
- R5: When `dir_sel[c]` is 0, bits enter at segment 0 from `lpin_i[c]` and move toward segment 39. `rpin_oe[c]`=1 and `rpin_o[c]` shows register bit 39. `lpin_oe[c]`=0, and `rpin_i[c]` is ignored.
- R6: The enabled serial output always presents the bit at the far end of the register. A bit shifted in therefore appears there after exactly 40 falling edges of `shift_stb`, which lets drivers be chained.
- R7: The code for segment i sits at `seg_lvl[2i+1:2i]`. Latched 1 with phase high gives 2'b00 (V1). Latched 1 with phase low gives 2'b01 (V2). Latched 0 with phase high gives 2'b10 (V3). Latched 0 with phase low gives 2'b11 (V4).
- R8: A change of `alt_in` changes the segment codes as R7 describes, with no new latch strobe needed.
- R9: The two channels shift and latch independently, each with its own direction and data. Channel 0 maps to segments 0 to 39 and channel 1 to segments 40 to 79.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_stb | input | 1 | Shift strobe, acted on at its falling edge |
| latch_stb | input | 1 | Latch strobe, acted on at its falling edge |
| alt_in | input | 1 | Frame phase (alternating signal) |
| dir_sel | input | 2 | Per-channel direction select |
| lpin_i | input | 2 | Left serial pin, input value |
| rpin_i | input | 2 | Right serial pin, input value |
| lpin_o | output | 2 | Left serial pin, output value |
| lpin_oe | output | 2 | Left serial pin, output enable |
| rpin_o | output | 2 | Right serial pin, output value |
| rpin_oe | output | 2 | Right serial pin, output enable |
| seg_lvl | output | 160 | Two-bit level code for each of the 80 segments |

## Verification
The hardest state to reach is a register whose far-end bit comes from a known data pattern pushed through all 40 stages, while the opposite pin is driven with the complement of that data. The stimulus feeds every shift with complementary values on both pins of each channel, so any leak from the ignored pin shows up. It runs two different patterns on the two channels at once, first with opposite directions and then with the directions swapped. A check between each strobe's rising and falling edge confirms that nothing moves before the falling edge. Reset is applied again in mid-stream with the phase high, to see that the latches are cleared.

// File: rtl/lcd_seg_pkg.sv
package lcd_seg_pkg;

  // Drive level selection per segment
  typedef enum logic [1:0] {
    LV_ON_HI  = 2'b00,  // V1
    LV_ON_LO  = 2'b01,  // V2
    LV_OFF_HI = 2'b10,  // V3
    LV_OFF_LO = 2'b11   // V4
  } lvl_e;

  function automatic lvl_e pick_level(input logic on_bit, input logic phase);
    case ({on_bit, phase})
      2'b11:   return LV_ON_HI;
      2'b10:   return LV_ON_LO;
      2'b01:   return LV_OFF_HI;
      default: return LV_OFF_LO;
    endcase
  endfunction

endpackage

// File: rtl/sync_pipe.sv
module sync_pipe #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/fall_detect.sv
module fall_detect (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic fall
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign fall = prev_q & ~lvl;

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);  // R2

endmodule

// File: rtl/seg_channel.sv
module seg_channel #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dir,
  input  logic         shift_fire,
  input  logic         latch_fire,
  input  logic         l_in,
  input  logic         r_in,
  output logic [W-1:0] latch_q,
  output logic         l_out,
  output logic         l_oe,
  output logic         r_out,
  output logic         r_oe
);

  logic [W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (shift_fire) begin
      if (dir) sr_q <= {r_in, sr_q[W-1:1]};
      else     sr_q <= {sr_q[W-2:0], l_in};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             latch_q <= '0;
    else if (latch_fire) latch_q <= sr_q;
  end

  assign l_oe  = dir;
  assign r_oe  = ~dir;
  assign l_out = dir & sr_q[0];
  assign r_out = ~dir & sr_q[W-1];

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (sr_q == '0 && latch_q == '0));  // R1
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !shift_fire |=> $stable(sr_q));  // R2
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !latch_fire |=> $stable(latch_q));  // R3
  AST_LATCH_COPY: assert property (@(posedge clk) disable iff (rst)
    latch_fire |=> latch_q == $past(sr_q));  // R3
  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (shift_fire && dir && $stable(dir)) |=> sr_q[W-2:0] == $past(sr_q[W-1:1]));  // R4
  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (rst)
    (shift_fire && !dir && $stable(dir)) |=> sr_q[W-1:1] == $past(sr_q[W-2:0]));  // R5
  AST_CASCADE_OUT: assert property (@(posedge clk) disable iff (rst)
    (shift_fire && !dir && $stable(dir)) |=> (!dir || r_out == $past(sr_q[W-2])));  // R6

endmodule

// File: rtl/level_bank.sv
module level_bank
  import lcd_seg_pkg::*;
#(
  parameter int W = 40
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   bits,
  input  logic           phase,
  output logic [2*W-1:0] codes
);

  for (genvar i = 0; i < W; i++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst) codes[2*i +: 2] <= LV_OFF_LO;
      else     codes[2*i +: 2] <= pick_level(bits[i], phase);
    end
  end

endmodule

// File: rtl/dual_seg_driver.sv
module dual_seg_driver #(
  parameter int SEG_PER_CH = 40,
  parameter int NUM_CH     = 2,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           shift_stb,
  input  logic                           latch_stb,
  input  logic                           alt_in,
  input  logic [NUM_CH-1:0]              dir_sel,
  input  logic [NUM_CH-1:0]              lpin_i,
  input  logic [NUM_CH-1:0]              rpin_i,
  output logic [NUM_CH-1:0]              lpin_o,
  output logic [NUM_CH-1:0]              lpin_oe,
  output logic [NUM_CH-1:0]              rpin_o,
  output logic [NUM_CH-1:0]              rpin_oe,
  output logic [2*SEG_PER_CH*NUM_CH-1:0] seg_lvl
);

  localparam int SYNC_W = 3 + 2*NUM_CH;

  logic [SYNC_W-1:0] raw_in, sync_out;
  logic              shift_s, latch_s, alt_s;
  logic [NUM_CH-1:0] lin_s, rin_s;
  logic              shift_fire, latch_fire;

  assign raw_in = {alt_in, latch_stb, shift_stb, rpin_i, lpin_i};

  sync_pipe #(.WIDTH(SYNC_W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_out)
  );

  assign {alt_s, latch_s, shift_s, rin_s, lin_s} = sync_out;

  fall_detect u_shift_edge (.clk(clk), .rst(rst), .lvl(shift_s), .fall(shift_fire));
  fall_detect u_latch_edge (.clk(clk), .rst(rst), .lvl(latch_s), .fall(latch_fire));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SEG_PER_CH-1:0] lat;

    seg_channel #(.W(SEG_PER_CH)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .dir        (dir_sel[c]),
      .shift_fire (shift_fire),
      .latch_fire (latch_fire),
      .l_in       (lin_s[c]),
      .r_in       (rin_s[c]),
      .latch_q    (lat),
      .l_out      (lpin_o[c]),
      .l_oe       (lpin_oe[c]),
      .r_out      (rpin_o[c]),
      .r_oe       (rpin_oe[c])
    );

    level_bank #(.W(SEG_PER_CH)) u_lvl (
      .clk   (clk),
      .rst   (rst),
      .bits  (lat),
      .phase (alt_s),
      .codes (seg_lvl[2*SEG_PER_CH*c +: 2*SEG_PER_CH])
    );

    AST_PIN_ROLES: assert property (@(posedge clk) disable iff (rst)
      lpin_oe[c] != rpin_oe[c]);  // R4 R5
  end

endmodule

// File: tb/tb_dual_seg_driver.sv
module tb_dual_seg_driver;
  localparam int W  = 40;
  localparam int NC = 2;
  localparam int NS = W*NC;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, shift_stb, latch_stb, alt_in;
  logic [NC-1:0] dir_sel, lpin_i, rpin_i, lpin_o, lpin_oe, rpin_o, rpin_oe;
  logic [2*NS-1:0] seg_lvl;

  dual_seg_driver dut (
    .clk(clk), .rst(rst), .shift_stb(shift_stb), .latch_stb(latch_stb),
    .alt_in(alt_in), .dir_sel(dir_sel), .lpin_i(lpin_i), .rpin_i(rpin_i),
    .lpin_o(lpin_o), .lpin_oe(lpin_oe), .rpin_o(rpin_o), .rpin_oe(rpin_oe),
    .seg_lvl(seg_lvl)
  );

  typedef struct {
    string           tag;
    logic [2*NS-1:0] seg;
    logic [NC-1:0]   lo, ro, loe, roe;
  } item_t;

  item_t q[$];
  bit    busy = 1'b0;
  int    n_run = 0, n_fail = 0;

  logic [W-1:0] m_sr [NC];
  logic [W-1:0] m_lat[NC];
  logic         m_alt;

  function automatic item_t build(string tag);
    item_t it;
    it.tag = tag;
    for (int c = 0; c < NC; c++) begin
      for (int i = 0; i < W; i++)
        it.seg[2*(c*W+i) +: 2] = {~m_lat[c][i], ~m_alt};  // R7 encoding
      it.loe[c] = dir_sel[c];
      it.roe[c] = ~dir_sel[c];
      it.lo[c]  = m_sr[c][0];
      it.ro[c]  = m_sr[c][W-1];
    end
    return it;
  endfunction

  task automatic check(string tag);
    q.push_back(build(tag));
    wait (q.size() == 0);
    wait (!busy);
  endtask

  // Monitor: pop expected items and compare against the outputs
  initial begin
    item_t it;
    forever begin
      wait (q.size() != 0);
      busy = 1'b1;
      it = q.pop_front();
      repeat (2) @(negedge clk);
      n_run++;
      if (seg_lvl !== it.seg) begin
        n_fail++;
        $display("FAIL %s seg_lvl got %h exp %h", it.tag, seg_lvl, it.seg);
      end
      if (lpin_oe !== it.loe || rpin_oe !== it.roe) begin
        n_fail++;
        $display("FAIL %s oe got l=%b r=%b exp l=%b r=%b", it.tag, lpin_oe, rpin_oe, it.loe, it.roe);
      end
      for (int c = 0; c < NC; c++) begin
        if (it.loe[c] && lpin_o[c] !== it.lo[c]) begin
          n_fail++;
          $display("FAIL %s lpin_o[%0d] got %b exp %b", it.tag, c, lpin_o[c], it.lo[c]);
        end
        if (it.roe[c] && rpin_o[c] !== it.ro[c]) begin
          n_fail++;
          $display("FAIL %s rpin_o[%0d] got %b exp %b", it.tag, c, rpin_o[c], it.ro[c]);
        end
      end
      busy = 1'b0;
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < NC; c++) begin m_sr[c] = '0; m_lat[c] = '0; end
    repeat (5) @(negedge clk);
  endtask

  // Drive data on the input pin and its complement on the ignored pin
  task automatic shift_in(input logic [NC-1:0] d, input string tag);
    for (int c = 0; c < NC; c++) begin
      if (dir_sel[c]) begin rpin_i[c] = d[c]; lpin_i[c] = ~d[c]; end
      else            begin lpin_i[c] = d[c]; rpin_i[c] = ~d[c]; end
    end
    shift_stb = 1'b1;
    repeat (4) @(negedge clk);
    check("R2");  // nothing moves while the strobe is high
    shift_stb = 1'b0;
    repeat (5) @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      if (dir_sel[c]) m_sr[c] = {d[c], m_sr[c][W-1:1]};
      else            m_sr[c] = {m_sr[c][W-2:0], d[c]};
    end
    check(tag);
  endtask

  task automatic latch_now();
    latch_stb = 1'b1;
    repeat (4) @(negedge clk);
    latch_stb = 1'b0;
    repeat (5) @(negedge clk);
    for (int c = 0; c < NC; c++) m_lat[c] = m_sr[c];
  endtask

  task automatic set_alt(input logic v);
    alt_in = v;
    m_alt  = v;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; shift_stb = 1'b0; latch_stb = 1'b0; alt_in = 1'b0; m_alt = 1'b0;
    dir_sel = 2'b10; lpin_i = '0; rpin_i = '0;
    do_reset();
    check("R1");

    // ch0 low-to-high (R5), ch1 high-to-low (R4); far-end bits emerge (R6)
    for (int i = 0; i < W; i++)
      shift_in({(i % 5) < 2, (i % 3) == 0}, "R6 R4 R5");
    for (int i = 0; i < 5; i++)
      shift_in({1'b0, 1'b1}, "R6");
    latch_now();
    check("R3 R9");
    set_alt(1'b1);
    check("R8 R7");
    set_alt(1'b0);
    check("R7");

    // shifting without a latch leaves segments alone
    for (int i = 0; i < 12; i++)
      shift_in({i[0], ~i[1]}, "R3");
    latch_now();
    check("R3");

    // swap directions on both channels
    dir_sel = 2'b01;
    repeat (3) @(negedge clk);
    check("R4 R5");
    for (int i = 0; i < W; i++)
      shift_in({(i % 7) == 3, i[0]}, "R4 R5 R6");
    latch_now();
    set_alt(1'b1);
    check("R9 R7");

    // all ones with phase high: every segment V1
    for (int i = 0; i < W; i++)
      shift_in(2'b11, "R6");
    latch_now();
    check("R7");
    set_alt(1'b0);
    check("R7 R8");

    // reset in mid-stream with phase high
    set_alt(1'b1);
    shift_in(2'b10, "R2");
    do_reset();
    check("R1");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule